// File: doc/BRIEF.md
# Rename History Buffer with Recovery

This block keeps the speculative rename history of one hardware thread. Every time a destination operand is renamed, the rename stage pushes an entry holding the instruction's sequence number, the architectural register, the newly allocated physical register and the physical register that the architectural register mapped to before. On the same cycle the block tells the scoreboard that the new physical register is not ready yet.

When instructions commit, the block retires history from the oldest end. Each retired entry hands its previous physical register back to the free list, because no architectural state can refer to it any longer. When a misprediction is found, the block unwinds history from the youngest end. For each undone entry it writes the previous physical register back into the rename map and frees the new one. A full drain unwinds every entry in the same way. Recovery and retirement run as a small state machine that handles one entry per cycle and holds `busy` high while it works. The states are IDLE, COMMIT, SQUASH and DRAIN. The transitions are: IDLE to COMMIT on an accepted commit request, IDLE to SQUASH on an accepted squash request, IDLE to DRAIN on an accepted drain request, and each working state back to IDLE once it finds no further entry to remove.

The storage is a circular array with a head pointer for the oldest entry and a tail pointer for the youngest. `DEPTH` must be a power of two. Sequence numbers are unsigned. The system must keep them from wrapping while they are live in the buffer.

Top module: `rename_hist_buf`

## Requirements
- R1: `push_ready` is high when both of these hold: the buffer holds fewer than DEPTH entries, and either the controller is in COMMIT, or the controller is in IDLE with neither `squash_valid` nor `drain_req` asserted. A push is stored exactly when `push_valid` and `push_ready` are both high in a cycle. Entries are kept in push order.
- R2: In every cycle in which a push is stored, `sb_clr_valid` is high and `sb_clr_preg` equals `push_pnew` in that same cycle. In all other cycles `sb_clr_valid` is low.
- R3: An accepted squash with sequence number S removes, youngest first and one per cycle, every entry whose sequence number is greater than S. Removals start in the cycle after the request. Each removal raises `map_wr_valid` with the entry's architectural register on `map_wr_areg` and its previous physical register on `map_wr_preg`. In the same cycle it raises `free_valid` with the entry's new physical register on `free_preg`.
- R4: An accepted commit with sequence number C removes, oldest first and one per cycle, every entry whose sequence number is at most C. Removals start in the cycle after the request. Each removal raises `free_valid` with the entry's previous physical register and leaves `map_wr_valid` low.
- R5: A commit request is ignored when the buffer is empty or when the oldest entry's sequence number is greater than C. An ignored commit leaves `busy` low, produces no output strobe, and changes no entry.
- R6: A squash request is ignored when the buffer is empty or when no entry is younger than S. An ignored squash leaves `busy` low and produces no output strobe.
- R7: When a squash request and a commit request arrive in the same idle cycle, the squash is handled and the commit is dropped. A squash request also takes priority over a drain request.
- R8: An accepted drain removes every entry, youngest first, with the same outputs as a squash removal. Drain takes priority over commit.
- R9: `busy` is high from the cycle after an accepted request up to and including one cycle after the last removal, and low otherwise. No output strobe occurs while `busy` is low. Requests that arrive while `busy` is high are ignored.
- R10: While the buffer holds DEPTH entries, `push_ready` is low and a push is refused without changing the contents.
- R11: After reset the buffer is empty, `busy` is low, no strobe is active and `push_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Rename stage offers a history entry |
| push_seq | input | SEQ_W | Sequence number of the renaming instruction |
| push_areg | input | AREG_W | Architectural destination register |
| push_pnew | input | PREG_W | Newly allocated physical register |
| push_pprev | input | PREG_W | Physical register mapped before this rename |
| push_ready | output | 1 | Entry will be stored this cycle if offered |
| sb_clr_valid | output | 1 | Mark a physical register not ready |
| sb_clr_preg | output | PREG_W | Physical register to mark not ready |
| commit_valid | input | 1 | Retire history up to commit_seq |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Undo history younger than squash_seq |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| drain_req | input | 1 | Undo all history |
| map_wr_valid | output | 1 | Rename map restore write |
| map_wr_areg | output | AREG_W | Map entry to restore |
| map_wr_preg | output | PREG_W | Physical register to restore into the map |
| free_valid | output | 1 | Free-list return strobe |
| free_preg | output | PREG_W | Physical register returned to the free list |
| busy | output | 1 | Retirement or recovery in progress |

## Verification
The bench builds the block with DEPTH=8, SEQ_W=16, AREG_W=5 and PREG_W=7. A depth of eight lets random pushes fill the buffer often, so refused pushes and full-buffer drains come up many times in one run. It also keeps each recovery sequence short enough that every removal can be compared one by one against a reference model. With 16-bit sequence numbers that grow by one to three per push, no value wraps during the run. Register numbers are drawn at random, so a mix-up between the new and previous physical register fields, or between the youngest and oldest end, shows up as a mismatch.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_SQUASH = 2'd2,
        ST_DRAIN  = 2'd3
    } hb_state_e;
endpackage

// File: rtl/hb_store.sv
module hb_store #(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_pnew,
    input  logic [PREG_W-1:0] push_pprev,
    input  logic              pop_old,
    input  logic              pop_young,
    output logic [SEQ_W-1:0]  old_seq,
    output logic [PREG_W-1:0] old_pprev,
    output logic [SEQ_W-1:0]  young_seq,
    output logic [AREG_W-1:0] young_areg,
    output logic [PREG_W-1:0] young_pnew,
    output logic [PREG_W-1:0] young_pprev,
    output logic [CNT_W-1:0]  occ,
    output logic              empty,
    output logic              full
);
    logic [SEQ_W-1:0]  seq_mem   [DEPTH];
    logic [AREG_W-1:0] areg_mem  [DEPTH];
    logic [PREG_W-1:0] pnew_mem  [DEPTH];
    logic [PREG_W-1:0] pprev_mem [DEPTH];

    logic [PTR_W-1:0] head_q, tail_q, young_idx;
    logic [CNT_W-1:0] occ_q, occ_d;

    assign young_idx = tail_q - PTR_W'(1);
    assign occ_d     = occ_q + CNT_W'(push_en) - CNT_W'(pop_old) - CNT_W'(pop_young);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            occ_q <= occ_d;
            if (pop_old)        head_q <= head_q + PTR_W'(1);
            if (push_en)        tail_q <= tail_q + PTR_W'(1);
            else if (pop_young) tail_q <= young_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (push_en) begin
            seq_mem[tail_q]   <= push_seq;
            areg_mem[tail_q]  <= push_areg;
            pnew_mem[tail_q]  <= push_pnew;
            pprev_mem[tail_q] <= push_pprev;
        end
    end

    assign old_seq     = seq_mem[head_q];
    assign old_pprev   = pprev_mem[head_q];
    assign young_seq   = seq_mem[young_idx];
    assign young_areg  = areg_mem[young_idx];
    assign young_pnew  = pnew_mem[young_idx];
    assign young_pprev = pprev_mem[young_idx];
    assign occ         = occ_q;
    assign empty       = (occ_q == '0);
    assign full        = (occ_q == CNT_W'(DEPTH));
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl
    import hb_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             squash_valid,
    input  logic [SEQ_W-1:0] squash_seq,
    input  logic             commit_valid,
    input  logic [SEQ_W-1:0] commit_seq,
    input  logic             drain_req,
    input  logic             empty,
    input  logic [SEQ_W-1:0] old_seq,
    input  logic [SEQ_W-1:0] young_seq,
    output hb_state_e        state,
    output logic             undo,
    output logic             retire,
    output logic             push_ok
);
    hb_state_e        state_q, state_d;
    logic [SEQ_W-1:0] tgt_q, tgt_d;
    logic             young_gt_tgt, old_le_tgt;

    assign young_gt_tgt = !empty && (young_seq > tgt_q);
    assign old_le_tgt   = !empty && (old_seq <= tgt_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            tgt_q   <= '0;
        end else begin
            state_q <= state_d;
            tgt_q   <= tgt_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        tgt_d   = tgt_q;
        undo    = 1'b0;
        retire  = 1'b0;
        push_ok = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                push_ok = !squash_valid && !drain_req;
                if (squash_valid) begin
                    if (!empty && (young_seq > squash_seq)) begin
                        state_d = ST_SQUASH;
                        tgt_d   = squash_seq;
                    end
                end else if (drain_req) begin
                    if (!empty) state_d = ST_DRAIN;
                end else if (commit_valid) begin
                    if (!empty && (old_seq <= commit_seq)) begin
                        state_d = ST_COMMIT;
                        tgt_d   = commit_seq;
                    end
                end
            end
            ST_COMMIT: begin
                push_ok = 1'b1;
                retire  = old_le_tgt;
                if (!old_le_tgt) state_d = ST_IDLE;
            end
            ST_SQUASH: begin
                undo = young_gt_tgt;
                if (!young_gt_tgt) state_d = ST_IDLE;
            end
            ST_DRAIN: begin
                undo = !empty;
                if (empty) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/rename_hist_buf.sv
module rename_hist_buf
    import hb_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int SEQ_W  = 16,
    parameter int AREG_W = 5,
    parameter int PREG_W = 7,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [SEQ_W-1:0]  push_seq,
    input  logic [AREG_W-1:0] push_areg,
    input  logic [PREG_W-1:0] push_pnew,
    input  logic [PREG_W-1:0] push_pprev,
    output logic              push_ready,
    output logic              sb_clr_valid,
    output logic [PREG_W-1:0] sb_clr_preg,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              drain_req,
    output logic              map_wr_valid,
    output logic [AREG_W-1:0] map_wr_areg,
    output logic [PREG_W-1:0] map_wr_preg,
    output logic              free_valid,
    output logic [PREG_W-1:0] free_preg,
    output logic              busy
);
    hb_state_e         state;
    logic              undo, retire, push_ok, push_en;
    logic              empty, full;
    logic [CNT_W-1:0]  occ;
    logic [SEQ_W-1:0]  old_seq, young_seq;
    logic [PREG_W-1:0] old_pprev, young_pnew, young_pprev;
    logic [AREG_W-1:0] young_areg;

    assign push_ready = push_ok && !full;
    assign push_en    = push_valid && push_ready;

    hb_store #(
        .DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_seq   (push_seq),
        .push_areg  (push_areg),
        .push_pnew  (push_pnew),
        .push_pprev (push_pprev),
        .pop_old    (retire),
        .pop_young  (undo),
        .old_seq    (old_seq),
        .old_pprev  (old_pprev),
        .young_seq  (young_seq),
        .young_areg (young_areg),
        .young_pnew (young_pnew),
        .young_pprev(young_pprev),
        .occ        (occ),
        .empty      (empty),
        .full       (full)
    );

    hb_ctrl #(.SEQ_W(SEQ_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .squash_valid(squash_valid),
        .squash_seq  (squash_seq),
        .commit_valid(commit_valid),
        .commit_seq  (commit_seq),
        .drain_req   (drain_req),
        .empty       (empty),
        .old_seq     (old_seq),
        .young_seq   (young_seq),
        .state       (state),
        .undo        (undo),
        .retire      (retire),
        .push_ok     (push_ok)
    );

    assign sb_clr_valid = push_en;
    assign sb_clr_preg  = push_pnew;
    assign map_wr_valid = undo;
    assign map_wr_areg  = young_areg;
    assign map_wr_preg  = young_pprev;
    assign free_valid   = undo || retire;
    assign free_preg    = undo ? young_pnew : old_pprev;
    assign busy         = (state != ST_IDLE);
endmodule

// File: rtl/hb_checker.sv
module hb_checker #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             free_valid,
    input logic             map_wr_valid,
    input logic             sb_clr_valid,
    input logic             push_ready,
    input logic             squash_valid,
    input logic             commit_valid,
    input logic             drain_req,
    input logic [CNT_W-1:0] occ
);
    // R3 / R8: every map restore is paired with a free of the new register
    a_r3_undo_frees: assert property (@(posedge clk) disable iff (!rst_n)
        map_wr_valid |-> free_valid);

    // R9: nothing leaves the buffer while idle
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!free_valid && !map_wr_valid));

    // R9: work only starts after a request
    a_r9_req_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(squash_valid || drain_req || commit_valid));

    // R10: occupancy bounded, no acceptance when full
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (occ <= CNT_W'(DEPTH)) && (push_ready -> (occ < CNT_W'(DEPTH))));

    // R1: a removal without a push shrinks occupancy by one
    a_r1_shrink: assert property (@(posedge clk) disable iff (!rst_n)
        (free_valid && !sb_clr_valid) |=> (occ == $past(occ) - CNT_W'(1)));

    // R1: a push without a removal grows occupancy by one
    a_r1_grow: assert property (@(posedge clk) disable iff (!rst_n)
        (sb_clr_valid && !free_valid) |=> (occ == $past(occ) + CNT_W'(1)));
endmodule

bind rename_hist_buf hb_checker #(.DEPTH(DEPTH)) u_hb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .free_valid  (free_valid),
    .map_wr_valid(map_wr_valid),
    .sb_clr_valid(sb_clr_valid),
    .push_ready  (push_ready),
    .squash_valid(squash_valid),
    .commit_valid(commit_valid),
    .drain_req   (drain_req),
    .occ         (occ)
);

// File: tb/rename_hist_buf_tb_top.sv
`timescale 1ns/1ps
module rename_hist_buf_tb_top;
    localparam int DEPTH  = 8;
    localparam int SEQ_W  = 16;
    localparam int AREG_W = 5;
    localparam int PREG_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 1'b0;
    logic [SEQ_W-1:0]  push_seq = '0;
    logic [AREG_W-1:0] push_areg = '0;
    logic [PREG_W-1:0] push_pnew = '0, push_pprev = '0;
    logic push_ready, sb_clr_valid;
    logic [PREG_W-1:0] sb_clr_preg;
    logic commit_valid = 1'b0, squash_valid = 1'b0, drain_req = 1'b0;
    logic [SEQ_W-1:0] commit_seq = '0, squash_seq = '0;
    logic map_wr_valid, free_valid, busy;
    logic [AREG_W-1:0] map_wr_areg;
    logic [PREG_W-1:0] map_wr_preg, free_preg;

    always #2.5 clk = ~clk;

    rename_hist_buf #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .AREG_W(AREG_W), .PREG_W(PREG_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_seq(push_seq), .push_areg(push_areg),
        .push_pnew(push_pnew), .push_pprev(push_pprev), .push_ready(push_ready),
        .sb_clr_valid(sb_clr_valid), .sb_clr_preg(sb_clr_preg),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .drain_req(drain_req),
        .map_wr_valid(map_wr_valid), .map_wr_areg(map_wr_areg), .map_wr_preg(map_wr_preg),
        .free_valid(free_valid), .free_preg(free_preg), .busy(busy)
    );

    int total = 0;
    int bad = 0;
    int nseq = 1;

    int m_n = 0;
    int m_seq [DEPTH];
    int m_areg [DEPTH];
    int m_pnew [DEPTH];
    int m_pprev [DEPTH];

    int exp_ev [2*DEPTH];
    int obs_ev [2*DEPTH];

    function automatic int mk_ev(int mv, int a, int mp, int fp);
        return (mv << 24) | (a << 16) | (mp << 8) | fp;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic do_push(input int a, input int pn, input int pp);
        bit exp_rdy;
        exp_rdy = (m_n < DEPTH);
        @(negedge clk);
        push_valid = 1'b1;
        push_seq   = SEQ_W'(nseq);
        push_areg  = AREG_W'(a);
        push_pnew  = PREG_W'(pn);
        push_pprev = PREG_W'(pp);
        #1;
        if (exp_rdy) chk(push_ready == 1'b1, "R1 push_ready", int'(push_ready), 1);
        else         chk(push_ready == 1'b0, "R10 push_ready when full", int'(push_ready), 0);
        chk(sb_clr_valid == exp_rdy && (!exp_rdy || sb_clr_preg == PREG_W'(pn)),
            "R2 scoreboard mark", {sb_clr_valid, 8'(sb_clr_preg)}, {exp_rdy, 8'(pn)});
        @(posedge clk);
        #1;
        push_valid = 1'b0;
        if (exp_rdy) begin
            m_seq[m_n] = nseq; m_areg[m_n] = a; m_pnew[m_n] = pn; m_pprev[m_n] = pp;
            m_n++;
            nseq = nseq + 1 + int'($urandom % 3);
        end
    endtask

    task automatic do_req(input bit sq, input int s, input bit cm, input int c, input bit dr);
        int n_exp;
        int n_obs;
        int cyc;
        bit acc;
        string tag;
        n_exp = 0;
        acc = 1'b0;
        if (sq) begin
            tag = cm ? "R7 squash over commit" : "R3 squash";
            if (m_n > 0 && m_seq[m_n-1] > s) acc = 1'b1;
            else tag = "R6 ignored squash";
            if (acc) begin
                while (m_n > 0 && m_seq[m_n-1] > s) begin
                    m_n--;
                    exp_ev[n_exp] = mk_ev(1, m_areg[m_n], m_pprev[m_n], m_pnew[m_n]);
                    n_exp++;
                end
            end
        end else if (dr) begin
            tag = "R8 drain";
            acc = (m_n > 0);
            while (m_n > 0) begin
                m_n--;
                exp_ev[n_exp] = mk_ev(1, m_areg[m_n], m_pprev[m_n], m_pnew[m_n]);
                n_exp++;
            end
        end else begin
            tag = "R4 commit";
            if (m_n > 0 && m_seq[0] <= c) acc = 1'b1;
            else tag = "R5 ignored commit";
            if (acc) begin
                while (n_exp < m_n && m_seq[n_exp] <= c) begin
                    exp_ev[n_exp] = mk_ev(0, 0, 0, m_pprev[n_exp]);
                    n_exp++;
                end
                for (int k = 0; k + n_exp < m_n; k++) begin
                    m_seq[k] = m_seq[k+n_exp]; m_areg[k] = m_areg[k+n_exp];
                    m_pnew[k] = m_pnew[k+n_exp]; m_pprev[k] = m_pprev[k+n_exp];
                end
                m_n = m_n - n_exp;
            end
        end
        @(negedge clk);
        squash_valid = sq; squash_seq = SEQ_W'(s);
        commit_valid = cm; commit_seq = SEQ_W'(c);
        drain_req = dr;
        @(posedge clk);
        #1;
        squash_valid = 1'b0; commit_valid = 1'b0; drain_req = 1'b0;
        n_obs = 0;
        cyc = 0;
        for (int g = 0; g < 4*DEPTH; g++) begin
            @(negedge clk);
            if (free_valid && n_obs < 2*DEPTH) begin
                obs_ev[n_obs] = mk_ev(int'(map_wr_valid),
                                      map_wr_valid ? int'(map_wr_areg) : 0,
                                      map_wr_valid ? int'(map_wr_preg) : 0,
                                      int'(free_preg));
                n_obs++;
            end else if (free_valid) begin
                n_obs++;
            end
            if (!busy) break;
            cyc++;
        end
        chk(cyc == (acc ? n_exp + 1 : 0), {"R9 busy length ", tag}, cyc, acc ? n_exp + 1 : 0);
        chk(n_obs == n_exp, {tag, " removal count"}, n_obs, n_exp);
        for (int k = 0; k < n_exp && k < n_obs && k < 2*DEPTH; k++)
            chk(obs_ev[k] == exp_ev[k], {tag, " removal"}, obs_ev[k], exp_ev[k]);
    endtask

    function automatic int pick_seq();
        if (m_n == 0) return nseq;
        return m_seq[$urandom % m_n] - int'($urandom % 2);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int op;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !free_valid && !map_wr_valid && push_ready, "R11 reset state",
            {busy, free_valid, map_wr_valid, push_ready}, 4'b0001);

        do_req(0, 0, 1, 100, 0);                 // R5 commit on empty
        do_req(1, 0, 0, 0, 0);                   // R6 squash on empty
        do_push(3, 40, 20);
        do_push(4, 41, 21);
        do_push(3, 42, 40);
        do_req(0, 0, 1, 0, 0);                   // R5 oldest younger than C
        do_req(1, m_seq[2], 0, 0, 0);            // R6 nothing younger
        do_req(1, m_seq[0], 1, m_seq[1], 0);     // R7 squash beats commit
        do_req(0, 0, 1, m_seq[0], 0);            // R4 single commit
        for (int i = 0; i < DEPTH + 1; i++)
            do_push(i, 60 + i, 90 + i);          // last one refused (R10)
        do_req(0, 0, 1, m_seq[DEPTH-1], 1);      // R8 drain beats commit

        for (int it = 0; it < 500; it++) begin
            op = int'($urandom % 10);
            if (op < 6) do_push(int'($urandom % 32), int'($urandom % 128), int'($urandom % 128));
            else if (op < 8) do_req(0, 0, 1, pick_seq(), 0);
            else if (op == 8) do_req(1, pick_seq(), int'($urandom % 2), pick_seq(), 0);
            else if ($urandom % 4 == 0) do_req(0, 0, 0, 0, 1);
            else do_push(int'($urandom % 32), int'($urandom % 128), int'($urandom % 128));
        end
        do_req(0, 0, 0, 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule